// File: doc/BRIEF.md
# Register-Cached Data Stack

This block holds the operand stack of a small stack processor. The topmost element sits in a register (`st0`). Every deeper element lives in a small RAM, and a pointer into that RAM always names the second element. With the top element already in a register, a two-operand operation needs only one RAM access to have both operands in hand.

An external sequencer drives the block through two alternating phases, chosen with `wr_phase`:

- **Read phase:** the block captures the RAM slot under the pointer into the registered second-element output. It then moves the pointer by the requested delta.
- **Write phase:** the block can store the current top element into the slot under the updated pointer. It can also load a new top value, which the surrounding datapath computes from `st0` and `st1`.

These two phases combine into the usual stack operations:

| Operation | Read-phase delta | Write phase |
|---|---|---|
| Push | up | store the top, load the pushed value |
| Pop | down | load `st1` into the top |
| Binary operation | down | load the result into the top |
| Swap | hold | store the top, load `st1` |

A saturating depth counter reports how many elements are stored below the top register.

Top module: `data_stack`

## Requirements
- R1: After reset, `st0`, `st1` and `depth` are all zero.
- R2: On a clock edge with `wr_phase`=0, `st1` takes the RAM slot addressed by the pointer before the edge, and `st0` keeps its value. The pointer then moves according to `ptr_delta`: 2'b01 adds one, 2'b11 subtracts one, and 2'b00 or 2'b10 holds.
- R3: On a clock edge with `wr_phase`=1, `wr_st1`=1 stores the pre-edge `st0` into the slot under the current pointer. In the same phase, `ld_st0`=1 loads `new_st0` into `st0`.
- R4: `depth` rises by one on a read phase with delta 2'b01 and saturates at N (16). It falls by one on a read phase with delta 2'b11 and saturates at 0.
- R5: The pointer wraps modulo N. After more than N pushes, the oldest slots are overwritten, and later pops return the newest N stored values.
- R6: `st1` holds its captured value through the write phase, even when that phase overwrites the same slot.
- R7: `ld_st0` and `wr_st1` are ignored during a read phase, and `ptr_delta` is ignored during a write phase.
- R8: A push (up, then store and load) followed by a pop (down, then load `st1`) returns the previously pushed values in reverse order.
- R9: A binary operation (down, then load `f(st0, st1)`) and a swap (hold, then store and load `st1`) leave the expected top two elements in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_phase | input | 1 | 0 = read phase, 1 = write phase |
| ptr_delta | input | 2 | Pointer move during a read phase: 01 up, 11 down, otherwise hold |
| wr_st1 | input | 1 | Write-phase store of `st0` into the second-element slot |
| ld_st0 | input | 1 | Write-phase load of `new_st0` into the top register |
| new_st0 | input | W | Value to load into the top register |
| st0 | output | W | Top element |
| st1 | output | W | Second element as captured in the last read phase |
| depth | output | $clog2(N+1) | Number of elements stored below the top, saturating at 0 and N |

## Verification
The block is exercised with several operation sequences:

- **Rising sweep of pushes:** twenty distinct values are pushed, which runs past the RAM size. This separates correct modulo wrap of the pointer from saturation of the depth counter.
- **Full set of pops, plus one more:** popping everything shows last-in-first-out order. The surplus pop shows that the depth floor holds while the pointer still wraps.
- **Binary additions:** interleaved additions over pushed operands show that the second operand comes from the slot addressed before the pointer moves.
- **Swaps:** swaps test read-before-write on a single slot.
- **Strobes in the wrong phase:** each strobe is raised in the phase where it must do nothing. This distinguishes phase gating from plain enable decoding.

// File: rtl/data_stack.sv
module data_stack #(
  parameter int W = 16,
  parameter int N = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_phase,
  input  logic [1:0]             ptr_delta,
  input  logic                   wr_st1,
  input  logic                   ld_st0,
  input  logic [W-1:0]           new_st0,
  output logic [W-1:0]           st0,
  output logic [W-1:0]           st1,
  output logic [$clog2(N+1)-1:0] depth
);
  localparam int PW = $clog2(N);
  localparam int CW = $clog2(N+1);
  localparam logic [PW-1:0] LAST = PW'(N-1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [W-1:0]  mem [N];
  logic [PW-1:0] ptr;

  wire rd_step = !wr_phase;
  wire up      = rd_step && (ptr_delta == 2'b01);
  wire dn      = rd_step && (ptr_delta == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0   <= '0;
      st1   <= '0;
      ptr   <= '0;
      depth <= '0;
    end else if (rd_step) begin
      st1 <= mem[ptr];
      if (up) begin
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        if (depth != FULL) depth <= depth + 1'b1;
      end else if (dn) begin
        ptr <= (ptr == '0) ? LAST : ptr - 1'b1;
        if (depth != '0) depth <= depth - 1'b1;
      end
    end else if (ld_st0) begin
      st0 <= new_st0;
    end
  end

  always_ff @(posedge clk)
    if (wr_phase && wr_st1) mem[ptr] <= st0;

endmodule

module data_stack_chk #(
  parameter int W = 16,
  parameter int N = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_phase,
  input logic [1:0]             ptr_delta,
  input logic                   wr_st1,
  input logic                   ld_st0,
  input logic [W-1:0]           new_st0,
  input logic [W-1:0]           st0,
  input logic [W-1:0]           st1,
  input logic [$clog2(N+1)-1:0] depth
);
  // R2
  rd_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_phase |=> $stable(st0));
  // R3
  ld_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && ld_st0) |=> st0 == $past(new_st0));
  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= ($clog2(N+1))'(N));
  // R4
  depth_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_phase && ptr_delta == 2'b01 && depth != ($clog2(N+1))'(N)) |=> depth == $past(depth) + 1'b1);
  // R4
  depth_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_phase && ptr_delta == 2'b11 && depth == '0) |=> depth == '0);
  // R6
  st1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> $stable(st1));
  // R7
  wr_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> $stable(depth));
  // R7
  rd_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_phase && ld_st0) |=> $stable(st0));
endmodule

bind data_stack data_stack_chk #(.W(W), .N(N)) u_chk (.*);

// File: tb/data_stack_bench.sv
module data_stack_bench;
  localparam int W = 16;
  localparam int N = 16;
  localparam int CW = $clog2(N+1);

  logic clk = 0;
  logic rst_n = 0;
  logic wr_phase = 0;
  logic [1:0] ptr_delta = 2'b00;
  logic wr_st1 = 0, ld_st0 = 0;
  logic [W-1:0] new_st0 = '0;
  logic [W-1:0] st0, st1;
  logic [CW-1:0] depth;

  data_stack #(.W(W), .N(N)) u_data_stack (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_st0 = '0, m_st1 = '0;
  logic [W-1:0] m_mem [N];
  int m_ptr = 0, m_depth = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] d, bit junk, string req);
    wr_phase = 0; ptr_delta = d;
    ld_st0 = junk; wr_st1 = junk; new_st0 = 16'hDEAD;
    @(posedge clk); #5;
    m_st1 = m_mem[m_ptr];
    if (d == 2'b01) begin
      m_ptr = (m_ptr + 1) % N;
      if (m_depth < N) m_depth++;
    end else if (d == 2'b11) begin
      m_ptr = (m_ptr + N - 1) % N;
      if (m_depth > 0) m_depth--;
    end
    chk({req, " st1"}, st1, m_st1);
    chk({req, " depth"}, depth, m_depth);
    chk({req, " st0"}, st0, m_st0);
  endtask

  task automatic wr(bit ld, bit w, logic [W-1:0] v, logic [1:0] d, string req);
    wr_phase = 1; ptr_delta = d; ld_st0 = ld; wr_st1 = w; new_st0 = v;
    @(posedge clk); #5;
    if (w) m_mem[m_ptr] = m_st0;
    if (ld) m_st0 = v;
    chk({req, " st0"}, st0, m_st0);
    chk({req, " st1"}, st1, m_st1);
    chk({req, " depth"}, depth, m_depth);
  endtask

  task automatic push(logic [W-1:0] v);
    rd(2'b01, 0, "R8 push");
    wr(1, 1, v, 2'b00, "R3 push");
  endtask

  task automatic pop();
    rd(2'b11, 0, "R8 pop");
    wr(1, 0, m_st1, 2'b00, "R8 pop");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1 st0", st0, 0);
    chk("R1 st1", st1, 0);
    chk("R1 depth", depth, 0);
    rst_n = 1;
    // R5: push past capacity so the pointer wraps
    for (int i = 0; i < 20; i++) push(W'(16'h1000 + i * 16'h0111));
    chk("R4 saturated depth", depth, N);
    // R8/R5: pop all stored entries, then one extra (R4 floor)
    for (int i = 0; i < N; i++) pop();
    chk("R4 empty depth", depth, 0);
    rd(2'b11, 0, "R4 pop at empty");
    chk("R4 floor", depth, 0);
    // R9: binary additions
    for (int i = 0; i < 4; i++) begin
      push(W'(16'h0300 + i * 16'h0025));
      push(W'(16'h7000 - i * 16'h0101));
      rd(2'b11, 0, "R9 add");
      wr(1, 0, m_st0 + m_st1, 2'b00, "R9 add");
    end
    // R9/R6: swap reads and overwrites one slot
    push(16'hA5A5);
    push(16'h5A5A);
    for (int i = 0; i < 3; i++) begin
      rd(2'b00, 0, "R9 swap");
      wr(1, 1, m_st1, 2'b00, "R6 swap hold");
    end
    rd(2'b00, 0, "R9 swap result");
    // R7: strobes in the wrong phase
    rd(2'b00, 1, "R7 read-phase strobes");
    rd(2'b00, 0, "R7 slot untouched");
    rd(2'b10, 0, "R2 hold code 10");
    wr(0, 0, '0, 2'b01, "R7 write-phase delta");
    wr(0, 0, '0, 2'b11, "R7 write-phase delta");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule